// File: doc/BRIEF.md
# Buffered Two-Rail Serial Word Transmitter

This block queues up to eight 32-bit avionics data words, written in two 16-bit halves from a host port while transmission is held off. When the enable input goes high, it sends them one after another with no further attention from the host. Each word goes out least significant serial bit first, as 32 bits or in a shortened 25-bit format. The final bit carries either generated parity or the loaded data bit. The output is a return-to-zero pair of rails with a free-running bit clock beside it. An external line driver turns the rails into bus levels.

The host port is a valid/ready stream of half-words. `wr_last` marks the second half of a word. A beat is taken on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low for as long as `tx_en` is high. A beat offered while `wr_ready` is low is not taken and leaves no trace, so the host must hold or retry it once the transmitter is disabled. The bit time is the master clock divided by `FAST_DIV` or `SLOW_DIV`. A minimum null gap of `GAP_BITS` bit times separates consecutive words.

Top module: `a429_block_tx`

## Requirements
- R1: Words leave in the order they were completed. A first-half beat supplies serial bits 1 to 16, with its bit 0 sent first. A second-half beat supplies serial bits 17 to 32.
- R2: While `tx_en` is high, `wr_ready` is low and offered beats change neither the buffer nor the pending first half. While `tx_en` is low, `wr_ready` is high.
- R3: A second-half beat with no pending first half is dropped. A further first-half beat before the second half replaces the pending first half.
- R4: The buffer holds `DEPTH` words. A word completed while the buffer is full overwrites the most recently completed word.
- R5: `tx_empty` is high after reset. It stays high after a lone first half and goes low on the edge that takes the first completed word. It returns high once the final bit of the last buffered word has ended.
- R6: A one bit drives `rail_a` high for the first half of its bit time, and a zero bit does the same on `rail_b`. Both rails are low for the rest of the bit, during nulls and while idle. They are never high together.
- R7: `bit_clk` runs continuously with a period of one bit time, high for the first half. Every transmitted bit begins on a rising edge of `bit_clk`.
- R8: One bit time is `FAST_DIV` master clocks when `cfg_slow` is 0 and `SLOW_DIV` master clocks when it is 1.
- R9: With `cfg_short` = 1, a word is 25 bits long. The first half supplies bits 1 to 16 and bits 8:0 of the second half supply bits 17 to 25.
- R10: The final bit (bit 32, or bit 25 in short format) is parity when `parity_lock` = 1 or `cfg_par_en` = 1. Otherwise it is the loaded bit: second-half bit 15, or bit 8 in short format.
- R11: Generated parity makes the ones count over the whole word odd when `cfg_even` = 0 and even when `cfg_even` = 1.
- R12: Within one enable period, consecutive word starts are exactly word length plus `GAP_BITS` bit times apart. At least `GAP_BITS` null bit times always follow a word, including across a disable and re-enable.
- R13: If `tx_en` falls during a word, that word is completed and no further word starts. The remaining words stay buffered and are sent in order on re-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host half-word beat valid |
| wr_last | input | 1 | 0 = first half, 1 = second half of a word |
| wr_data | input | 16 | Half-word payload |
| wr_ready | output | 1 | Beat can be taken (high while disabled) |
| tx_en | input | 1 | Transmission enable |
| cfg_short | input | 1 | 1 selects 25-bit words |
| cfg_slow | input | 1 | 1 selects the slow bit rate |
| cfg_even | input | 1 | 1 inverts generated parity to even |
| cfg_par_en | input | 1 | Parity on final bit when `parity_lock` is 0 |
| parity_lock | input | 1 | 1 forces parity on the final bit |
| bit_clk | output | 1 | Free-running bit clock |
| rail_a | output | 1 | Return-to-zero rail for one bits |
| rail_b | output | 1 | Return-to-zero rail for zero bits |
| tx_empty | output | 1 | Buffer empty and no word in flight |

## Verification
The bench sweeps word format, parity source and parity sense against block sizes of one to eight words, and one further block overflows the buffer. A design that overwrote the oldest word instead of the newest, or that computed parity over the wrong span, would deliver a wrong decoded word. Orphaned second halves, replaced first halves and writes offered while enabled are each followed by a check of `tx_empty` and of the next transmitted block. A design that latched any of them would show up as an extra, missing or altered word. Word-start spacing is measured inside a block, across a re-enable and after an enable dropped mid-word. An off-by-one gap counter would shift the spacing by a bit time, and a design that aborted the word in flight would leave a truncated word.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned WORD_W = 32;

  typedef logic [HALF_W-1:0] a429_half_t;
  typedef logic [WORD_W-1:0] a429_word_t;

  // Final-bit handling for R9/R10/R11: bits above the short word are cleared,
  // and the last bit becomes parity over the bits before it when selected.
  function automatic a429_word_t a429_seal(input a429_word_t w, input logic short_fmt,
                                           input logic use_par, input logic even);
    a429_word_t span;
    a429_word_t r;
    logic       p;
    span = short_fmt ? a429_word_t'(32'h00FF_FFFF) : a429_word_t'(32'h7FFF_FFFF);
    r    = short_fmt ? (w & a429_word_t'(32'h01FF_FFFF)) : w;
    p    = ~(^(w & span)) ^ even;
    if (use_par) begin
      if (short_fmt) r[24] = p;
      else           r[31] = p;
    end
    return r;
  endfunction
endpackage

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo
  import a429_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  a429_word_t push_word,
  input  logic       pop,
  output a429_word_t head,
  output logic       empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

  a429_word_t    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          full, pop_ok, push_new, push_ovw;
  logic [AW-1:0] wr_next, rd_next, wr_prev, wr_addr;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign pop_ok   = pop && !empty;
  assign push_new = push && (!full || pop_ok);
  // R4: full buffer, new word replaces the most recently written one
  assign push_ovw = push && full && !pop_ok;

  assign wr_next = (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
  assign rd_next = (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + 1'b1;
  assign wr_prev = (wr_ptr == '0) ? LAST_SLOT : wr_ptr - 1'b1;
  assign wr_addr = push_ovw ? wr_prev : wr_ptr;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_new || push_ovw) mem[wr_addr] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_new) wr_ptr <= wr_next;
      if (pop_ok)   rd_ptr <= rd_next;
      if (push_new && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !push_new) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/a429_bit_timer.sv
module a429_bit_timer #(
  parameter int unsigned FAST_DIV = 10,
  parameter int unsigned SLOW_DIV = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow,
  output logic tick,
  output logic bit_clk
);
  localparam int unsigned MAXDIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int unsigned CW     = $clog2(MAXDIV);

  logic [CW-1:0] cnt, limit, half;

  // R8: bit time selection
  assign limit   = slow ? CW'(SLOW_DIV - 1) : CW'(FAST_DIV - 1);
  assign half    = slow ? CW'(SLOW_DIV / 2) : CW'(FAST_DIV / 2);
  assign tick    = (cnt >= limit);
  // R7: high in the first half of every bit time
  assign bit_clk = (cnt < half);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/a429_tx_serializer.sv
module a429_tx_serializer
  import a429_tx_pkg::*;
#(
  parameter int unsigned GAP_BITS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       tx_en,
  input  logic       avail,
  input  a429_word_t head,
  input  logic       short_fmt,
  input  logic       use_par,
  input  logic       even,
  output logic       pop,
  output logic       sending,
  output logic       ser_bit
);
  localparam int unsigned GW = $clog2(GAP_BITS + 1);
  localparam logic [GW-1:0] GAP_TOP = GW'(GAP_BITS - 1);
  localparam int unsigned IW = $clog2(WORD_W);

  logic          busy;
  logic [GW-1:0] gap;
  logic [IW-1:0] idx, last_idx;
  a429_word_t    shreg;
  logic          start;

  // R12/R13: a word starts only on a bit boundary, while enabled,
  // after the null gap has run out
  assign start   = tick && !busy && tx_en && avail && (gap == GAP_TOP);
  assign pop     = start;
  assign sending = busy;
  assign ser_bit = shreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      gap      <= GAP_TOP;
      idx      <= '0;
      last_idx <= '0;
      shreg    <= '0;
    end else if (tick) begin
      if (busy) begin
        if (idx == last_idx) begin
          busy  <= 1'b0;
          gap   <= '0;
          shreg <= '0;
        end else begin
          idx   <= idx + 1'b1;
          shreg <= shreg >> 1;
        end
      end else if (start) begin
        busy     <= 1'b1;
        idx      <= '0;
        last_idx <= short_fmt ? IW'(24) : IW'(WORD_W - 1);
        shreg    <= a429_seal(head, short_fmt, use_par, even);
      end else if (gap != GAP_TOP) begin
        gap <= gap + 1'b1;
      end
    end
  end
endmodule

// File: rtl/a429_block_tx.sv
module a429_block_tx
  import a429_tx_pkg::*;
#(
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned FAST_DIV = 10,
  parameter int unsigned SLOW_DIV = 80,
  parameter int unsigned GAP_BITS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic        wr_last,
  input  logic [15:0] wr_data,
  output logic        wr_ready,
  input  logic        tx_en,
  input  logic        cfg_short,
  input  logic        cfg_slow,
  input  logic        cfg_even,
  input  logic        cfg_par_en,
  input  logic        parity_lock,
  output logic        bit_clk,
  output logic        rail_a,
  output logic        rail_b,
  output logic        tx_empty
);
  a429_half_t lo_hold;
  logic       lo_ok;
  logic       take, push, pop, fifo_empty, tick, sending, ser_bit;
  a429_word_t head;

  // R2: host port locked while enabled
  assign wr_ready = !tx_en;
  assign take     = wr_valid && wr_ready;
  // R3: second half only completes a word with a pending first half
  assign push     = take && wr_last && lo_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_hold <= '0;
      lo_ok   <= 1'b0;
    end else if (take) begin
      if (!wr_last) begin
        lo_hold <= wr_data;
        lo_ok   <= 1'b1;
      end else begin
        lo_ok   <= 1'b0;
      end
    end
  end

  a429_tx_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_word ({wr_data, lo_hold}),
    .pop       (pop),
    .head      (head),
    .empty     (fifo_empty)
  );

  a429_bit_timer #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .slow    (cfg_slow),
    .tick    (tick),
    .bit_clk (bit_clk)
  );

  a429_tx_serializer #(.GAP_BITS(GAP_BITS)) i_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .tx_en     (tx_en),
    .avail     (!fifo_empty),
    .head      (head),
    .short_fmt (cfg_short),
    .use_par   (parity_lock || cfg_par_en),
    .even      (cfg_even),
    .pop       (pop),
    .sending   (sending),
    .ser_bit   (ser_bit)
  );

  // R6: return-to-zero rails, active in the first half of each bit
  assign rail_a   = sending && ser_bit && bit_clk;
  assign rail_b   = sending && !ser_bit && bit_clk;
  // R5
  assign tx_empty = fifo_empty && !sending;
endmodule

// File: rtl/a429_block_tx_chk.sv
module a429_block_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic wr_ready,
  input logic rail_a,
  input logic rail_b,
  input logic bit_clk,
  input logic tx_empty
);
  a_r6_rails_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rail_a && rail_b));

  a_r7_rails_in_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_a || rail_b) |-> bit_clk);

  a_r6_rail_a_drops_with_clk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rail_a) |-> $fell(bit_clk));

  a_r5_idle_rails_low: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (!rail_a && !rail_b));

  a_r2_empty_holds_while_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && tx_en && !wr_ready) |=> tx_empty);
endmodule

bind a429_block_tx a429_block_tx_chk i_a429_block_tx_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_en    (tx_en),
  .wr_ready (wr_ready),
  .rail_a   (rail_a),
  .rail_b   (rail_b),
  .bit_clk  (bit_clk),
  .tx_empty (tx_empty)
);

// File: tb/test_a429_block_tx.sv
module test_a429_block_tx;
  localparam int DEPTH = 8;
  localparam int FD    = 10;
  localparam int SD    = 80;
  localparam int GAP   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, wr_last = 1'b0;
  logic [15:0] wr_data = '0;
  logic        tx_en = 1'b0, cfg_short = 1'b0, cfg_slow = 1'b0, cfg_even = 1'b0;
  logic        cfg_par_en = 1'b0, parity_lock = 1'b0;
  logic        wr_ready, bit_clk, rail_a, rail_b, tx_empty;

  always #5 clk = ~clk;

  a429_block_tx i_a429_block_tx (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_last(wr_last), .wr_data(wr_data),
    .wr_ready(wr_ready), .tx_en(tx_en), .cfg_short(cfg_short), .cfg_slow(cfg_slow),
    .cfg_even(cfg_even), .cfg_par_en(cfg_par_en), .parity_lock(parity_lock),
    .bit_clk(bit_clk), .rail_a(rail_a), .rail_b(rail_b), .tx_empty(tx_empty)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) cyc++;

  // ---------------- rail decoder ----------------
  int          exp_len = 32, exp_half = FD / 2;
  logic [31:0] cur = '0;
  int          bitcnt = 0, hw = 0, start_t = 0;
  logic [31:0] rx_w [0:255];
  int          rx_t [0:255];
  int          rx_n = 0, width_err = 0, align_err = 0;
  logic        pa = 1'b0, pb = 1'b0, pc = 1'b0;

  always @(negedge clk) begin
    if (rail_a || rail_b) begin
      if (!(pa || pb)) begin
        if (bitcnt == 0) start_t = cyc;
        if (bitcnt < 32) cur[bitcnt] = rail_a;
        bitcnt++;
        if (!(bit_clk && !pc)) align_err++;
        hw = 1;
      end else hw++;
    end else if (pa || pb) begin
      if (hw != exp_half) width_err++;
      if (bitcnt == exp_len) begin
        if (rx_n < 256) begin rx_w[rx_n] = cur; rx_t[rx_n] = start_t; end
        rx_n++;
        bitcnt = 0;
        cur = '0;
      end
    end
    pa = rail_a; pb = rail_b; pc = bit_clk;
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input bit last, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_last = last; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  function automatic logic [31:0] model_word(input logic [15:0] lo, input logic [15:0] hi,
                                             input bit sh, input bit par, input bit ev);
    logic [31:0] w;
    int last, ones;
    w = {hi, lo};
    last = sh ? 24 : 31;
    if (sh) for (int i = 25; i < 32; i++) w[i] = 1'b0;
    if (par) begin
      ones = 0;
      for (int i = 0; i < last; i++) ones += int'(w[i]);
      w[last] = ((ones % 2) == 0) ^ ev;
    end
    return w;
  endfunction

  logic [31:0] exp_w [0:15];
  int ne = 0, blk_base = 0, prev_end = -1, prev_div = 0;

  task automatic clear_model();
    ne = 0;
    blk_base = rx_n;
  endtask

  task automatic load_word(input logic [15:0] lo, input logic [15:0] hi);
    logic [31:0] w;
    put(1'b0, lo);
    put(1'b1, hi);
    w = model_word(lo, hi, cfg_short, cfg_par_en | parity_lock, cfg_even);
    if (ne < DEPTH) begin exp_w[ne] = w; ne++; end
    else exp_w[ne-1] = w;
  endtask

  function automatic int cur_div();
    return cfg_slow ? SD : FD;
  endfunction

  task automatic wait_empty();
    int lim;
    lim = (ne + 2) * (exp_len + GAP + 2) * cur_div();
    for (int t = 0; t < lim && !tx_empty; t++) @(negedge clk);
  endtask

  task automatic fire(input string tag, input bit strict);
    int d, werr0, aerr0;
    d = cur_div();
    werr0 = width_err; aerr0 = align_err;
    @(negedge clk); tx_en = 1'b1;
    wait_empty();
    @(negedge clk); tx_en = 1'b0;
    check(tx_empty == 1'b1, {tag, " R5 empty after block"}, 32'(tx_empty), 32'd1);
    check(rx_n - blk_base == ne, {tag, " R1 word count"}, 32'(rx_n - blk_base), 32'(ne));
    for (int i = 0; i < ne; i++)
      check(rx_w[blk_base+i] == exp_w[i], {tag, " R1 word content"}, rx_w[blk_base+i], exp_w[i]);
    for (int i = 1; i < ne; i++) begin
      if (strict)
        check(rx_t[blk_base+i] - rx_t[blk_base+i-1] == (exp_len + GAP) * d, {tag, " R12 spacing"},
              32'(rx_t[blk_base+i] - rx_t[blk_base+i-1]), 32'((exp_len + GAP) * d));
      else
        check(rx_t[blk_base+i] - rx_t[blk_base+i-1] >= (exp_len + GAP) * d, {tag, " R12 min spacing"},
              32'(rx_t[blk_base+i] - rx_t[blk_base+i-1]), 32'((exp_len + GAP) * d));
    end
    if (ne > 0 && prev_end >= 0 && prev_div == d)
      check(rx_t[blk_base] - prev_end >= GAP * d, {tag, " R12 gap across blocks"},
            32'(rx_t[blk_base] - prev_end), 32'(GAP * d));
    if (ne > 0) begin
      prev_end = rx_t[blk_base+ne-1] + exp_len * d;
      prev_div = d;
    end
    check(width_err == werr0, {tag, " R6 rail pulse width"}, 32'(width_err - werr0), 32'd0);
    check(align_err == aerr0, {tag, " R7 bit start on clock rise"}, 32'(align_err - aerr0), 32'd0);
  endtask

  task automatic measure_clk(input int div, input string tag);
    int hi, lo;
    hi = 0; lo = 0;
    while (bit_clk)  @(negedge clk);
    while (!bit_clk) @(negedge clk);
    while (bit_clk)  begin hi++; @(negedge clk); end
    while (!bit_clk) begin lo++; @(negedge clk); end
    check(hi == div / 2, {tag, " R7 clock high time"}, 32'(hi), 32'(div / 2));
    check(hi + lo == div, {tag, " R8 clock period"}, 32'(hi + lo), 32'(div));
  endtask

  task automatic set_cfg(input bit sh, input bit sl, input bit ev, input bit pen, input bit lk);
    @(negedge clk);
    cfg_short = sh; cfg_slow = sl; cfg_even = ev; cfg_par_en = pen; parity_lock = lk;
    exp_len  = sh ? 25 : 32;
    exp_half = (sl ? SD : FD) / 2;
  endtask

  task automatic run_block(input int k, input int seed);
    string tag;
    logic [15:0] lo, hi;
    tag = $sformatf("blk%0d k=%0d%s%s%s", seed, k, cfg_short ? " R9" : "",
                    (cfg_par_en | parity_lock) ? " R11" : " R10", k > DEPTH ? " R4" : "");
    clear_model();
    for (int i = 0; i < k; i++) begin
      lo = 16'(seed * 40503 + i * 7919 + 16'h3A5C);
      hi = 16'((seed * 12345) ^ (i * 4099) ^ (i[0] ? 16'h8100 : 16'h0000));
      if (i == 0) begin
        put(1'b0, lo);
        check(tx_empty == 1'b1, {tag, " R5 lone first half"}, 32'(tx_empty), 32'd1);
        put(1'b1, hi);
        check(tx_empty == 1'b0, {tag, " R5 first word taken"}, 32'(tx_empty), 32'd0);
        exp_w[0] = model_word(lo, hi, cfg_short, cfg_par_en | parity_lock, cfg_even);
        ne = 1;
      end else load_word(lo, hi);
    end
    fire(tag, 1'b1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (195000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_empty == 1'b1, "R5 reset empty", 32'(tx_empty), 32'd1);
    check(!rail_a && !rail_b, "R6 reset rails", {30'd0, rail_a, rail_b}, 32'd0);
    check(wr_ready == 1'b1, "R2 reset ready", 32'(wr_ready), 32'd1);
    measure_clk(FD, "fast");

    // sweep: format x parity sense x parity source, block sizes 1..8
    for (int r = 0; r < 16; r++) begin
      set_cfg(r[3], 1'b0, r[2], r[0], r[1]);
      run_block(1 + (r % 8), r);
    end

    // overflow: nine words, the ninth replaces the eighth (R4)
    set_cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    run_block(9, 21);

    // R2: beats offered while enabled are ignored
    @(negedge clk); tx_en = 1'b1;
    @(negedge clk);
    check(wr_ready == 1'b0, "R2 ready low while enabled", 32'(wr_ready), 32'd0);
    base = rx_n;
    put(1'b0, 16'h1234);
    put(1'b1, 16'h5678);
    repeat (20 * FD) @(negedge clk);
    check(tx_empty == 1'b1, "R2 no word taken while enabled", 32'(tx_empty), 32'd1);
    check(rx_n == base, "R2 nothing sent", 32'(rx_n - base), 32'd0);
    tx_en = 1'b0;
    @(negedge clk);
    check(wr_ready == 1'b1, "R2 ready high while disabled", 32'(wr_ready), 32'd1);
    put(1'b1, 16'h9ABC);
    check(tx_empty == 1'b1, "R2 R3 no pending first half kept", 32'(tx_empty), 32'd1);

    // R3: orphan second half dropped, repeated first half replaces
    clear_model();
    put(1'b1, 16'hDEAD);
    check(tx_empty == 1'b1, "R3 orphan second half dropped", 32'(tx_empty), 32'd1);
    put(1'b0, 16'h1111);
    load_word(16'hC0DE, 16'h0F0F);
    fire("R3 replaced first half", 1'b1);

    // R13: enable dropped mid-word
    set_cfg(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    clear_model();
    load_word(16'hAAAA, 16'h0155);
    load_word(16'h5555, 16'h00AA);
    load_word(16'h0F0F, 16'h01F0);
    @(negedge clk); tx_en = 1'b1;
    for (int t = 0; t < 100 * FD && !(rail_a || rail_b); t++) @(negedge clk);
    repeat (3 * FD) @(negedge clk);
    tx_en = 1'b0;
    repeat ((exp_len + GAP + 6) * FD) @(negedge clk);
    check(rx_n - blk_base == 1, "R13 in-flight word completed alone", 32'(rx_n - blk_base), 32'd1);
    check(tx_empty == 1'b0, "R13 rest stays buffered", 32'(tx_empty), 32'd0);
    fire("R13 resume", 1'b0);

    // slow rate
    set_cfg(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    measure_clk(SD, "slow");
    run_block(2, 30);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule